// File: doc/BRIEF.md
# Spanning Tree Port State Gate

This block sits beside each port of a switch and turns that port's spanning tree state into three per-frame permissions. For a frame that has started arriving, it says whether the frame may be forwarded and whether its source address may be learned. For a frame about to leave, it says whether the port may transmit it. Software, or a protocol engine, writes a 3-bit state code and a DMA enable bit for each port. The gate samples them only at frame starts.

The state codes are not contiguous. There are separate receive-only and transmit-only codes, and a learning code that learns addresses without forwarding. A disabled port is not a state code at all: it is a port whose DMA enable bit is clear, and that blocks every permission whatever the code says. Codes that have no meaning behave like listen.

Each frame start pulse latches a verdict. The verdict stays on the outputs until the next start of the same direction, so a state change made while a frame is in flight never cuts that frame. These are plain control pins with no valid/ready handshake. The gate never applies back-pressure: a start pulse is always accepted in the cycle it is high.

Top module: `stp_port_gate_top`

## Requirements
- R1: After reset, every rx_fwd, rx_learn and tx_ok bit is 0.
- R2: With dma_en set and state code 0 (listen, also used for blocking), a start gives rx_fwd=0, rx_learn=0 and tx_ok=0.
- R3: With dma_en set and state code 1 (receive only), a start gives rx_fwd=1, rx_learn=0 and tx_ok=0.
- R4: With dma_en set and state code 2 (transmit only), a start gives rx_fwd=0, rx_learn=0 and tx_ok=1.
- R5: With dma_en set and state code 3 (learning), a start gives rx_learn=1, rx_fwd=0 and tx_ok=0.
- R6: With dma_en set and state code 7 (forwarding), a start gives rx_fwd=1, rx_learn=1 and tx_ok=1.
- R7: State codes 4, 5 and 6 give the same verdict as code 0.
- R8: With dma_en clear (disabled), a start gives all three outputs 0 for any state code.
- R9: A verdict is taken from the state code and dma_en present at the clock edge where the start bit is high. It appears in the following cycle and holds until the next start in that direction, whatever the state inputs do in between.
- R10: rx_start updates only rx_fwd and rx_learn. tx_start updates only tx_ok.
- R11: Ports are independent. Port p's outputs depend only on slice p of port_state, dma_en and the start bits, where slice p of port_state is bits [3p+2:3p].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_state | input | NUM_PORTS*3 | State code per port, port p in bits [3p+2:3p] |
| dma_en | input | NUM_PORTS | Per-port DMA enable; 0 means disabled |
| rx_start | input | NUM_PORTS | One-cycle pulse at the start of a received frame |
| tx_start | input | NUM_PORTS | One-cycle pulse at the start of a frame to transmit |
| rx_fwd | output | NUM_PORTS | Current received frame may be forwarded |
| rx_learn | output | NUM_PORTS | Source address of current received frame may be learned |
| tx_ok | output | NUM_PORTS | Current frame may be transmitted on the port |

## Verification
The assertions assume that a start bit is sampled only on clock edges and that the state inputs are stable around those edges. They also assume nothing is driven during reset except idle start bits. The stimulus meets these assumptions: it changes every input on the falling edge and holds each start bit high for exactly one rising edge. It keeps the starts low between frames, so the hold properties check the latched verdict against state inputs that change on purpose mid-frame.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_LISTEN  = 3'd0,
    ST_RX_ONLY = 3'd1,
    ST_TX_ONLY = 3'd2,
    ST_LEARN   = 3'd3,
    ST_FORWARD = 3'd7
  } stp_code_e;

  typedef struct packed {
    logic fwd;
    logic learn;
    logic tx;
  } gate_verdict_t;
endpackage

// File: rtl/stp_state_decode.sv
module stp_state_decode
  import stp_gate_pkg::*;
(
  input  logic [STATE_W-1:0] state_code,
  input  logic               dma_on,
  output gate_verdict_t      verdict
);
  always_comb begin
    verdict = '0;
    if (dma_on) begin
      case (state_code)
        ST_RX_ONLY: verdict.fwd = 1'b1;
        ST_TX_ONLY: verdict.tx  = 1'b1;
        ST_LEARN:   verdict.learn = 1'b1;
        ST_FORWARD: begin
          verdict.fwd   = 1'b1;
          verdict.learn = 1'b1;
          verdict.tx    = 1'b1;
        end
        default:    verdict = '0;  // listen and unused codes 4..6
      endcase
    end
  end
endmodule

// File: rtl/stp_port_gate.sv
module stp_port_gate
  import stp_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_code,
  input  logic               dma_on,
  input  logic               rx_start,
  input  logic               tx_start,
  output logic               rx_fwd,
  output logic               rx_learn,
  output logic               tx_ok
);
  gate_verdict_t now_v;

  stp_state_decode u_dec (
    .state_code (state_code),
    .dma_on     (dma_on),
    .verdict    (now_v)
  );

  // Verdicts are latched only at frame starts, so mid-frame changes wait.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_fwd   <= 1'b0;
      rx_learn <= 1'b0;
      tx_ok    <= 1'b0;
    end else begin
      if (rx_start) begin
        rx_fwd   <= now_v.fwd;
        rx_learn <= now_v.learn;
      end
      if (tx_start) begin
        tx_ok <= now_v.tx;
      end
    end
  end

  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_start |=> $stable(rx_fwd) && $stable(rx_learn));
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start |=> $stable(tx_ok));
  p_rx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && !dma_on) |=> (!rx_fwd && !rx_learn));
  p_tx_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !dma_on) |=> !tx_ok);
  p_listen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && state_code == 3'd0) |=> (!rx_fwd && !rx_learn));
  p_learn_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && dma_on && state_code == 3'd3) |=> (rx_learn && !rx_fwd));
  p_full_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_start && tx_start && dma_on && state_code == 3'd7)
      |=> (rx_fwd && rx_learn && tx_ok));
endmodule

// File: rtl/stp_port_gate_top.sv
module stp_port_gate_top
  import stp_gate_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS*STATE_W-1:0] port_state,
  input  logic [NUM_PORTS-1:0]         dma_en,
  input  logic [NUM_PORTS-1:0]         rx_start,
  input  logic [NUM_PORTS-1:0]         tx_start,
  output logic [NUM_PORTS-1:0]         rx_fwd,
  output logic [NUM_PORTS-1:0]         rx_learn,
  output logic [NUM_PORTS-1:0]         tx_ok
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    stp_port_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_code (port_state[p*STATE_W +: STATE_W]),
      .dma_on     (dma_en[p]),
      .rx_start   (rx_start[p]),
      .tx_start   (tx_start[p]),
      .rx_fwd     (rx_fwd[p]),
      .rx_learn   (rx_learn[p]),
      .tx_ok      (tx_ok[p])
    );
  end

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (rx_fwd == '0 && rx_learn == '0 && tx_ok == '0));
endmodule

// File: tb/stp_port_gate_top_bench.sv
module stp_port_gate_top_bench;
  localparam int P = 4;
  logic clk = 1'b0;
  logic rst_n;
  logic [P*3-1:0] port_state;
  logic [P-1:0] dma_en, rx_start, tx_start, rx_fwd, rx_learn, tx_ok;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stp_port_gate_top #(.NUM_PORTS(P)) u_stp_port_gate_top (
    .clk(clk), .rst_n(rst_n), .port_state(port_state), .dma_en(dma_en),
    .rx_start(rx_start), .tx_start(tx_start),
    .rx_fwd(rx_fwd), .rx_learn(rx_learn), .tx_ok(tx_ok));

  function automatic logic [2:0] model(input logic [2:0] code, input logic en);
    if (!en) return 3'b000;           // {fwd, learn, tx}
    if (code == 3'd1) return 3'b100;
    if (code == 3'd2) return 3'b001;
    if (code == 3'd3) return 3'b010;
    if (code == 3'd7) return 3'b111;
    return 3'b000;
  endfunction

  task automatic chk(input string req, input int p, input logic [2:0] exp);
    logic [2:0] act;
    act = {rx_fwd[p], rx_learn[p], tx_ok[p]};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s port %0d: actual %b expected %b", req, p, act, exp);
    end
  endtask

  task automatic pulse(input logic [P-1:0] rxm, input logic [P-1:0] txm);
    rx_start = rxm; tx_start = txm;
    @(posedge clk); @(negedge clk);
    rx_start = '0; tx_start = '0;
  endtask

  task automatic code_case(input string req, input int p, input logic [2:0] code,
                           input logic en);
    port_state[p*3 +: 3] = code; dma_en[p] = en;
    pulse(P'(1) << p, P'(1) << p);
    chk(req, p, model(code, en));
  endtask

  task automatic t_reset_r1();
    for (int p = 0; p < P; p++) chk("R1", p, 3'b000);
  endtask

  task automatic t_codes();
    code_case("R2", 0, 3'd0, 1'b1);
    code_case("R3", 0, 3'd1, 1'b1);
    code_case("R4", 1, 3'd2, 1'b1);
    code_case("R5", 2, 3'd3, 1'b1);
    code_case("R6", 3, 3'd7, 1'b1);
    code_case("R3", 1, 3'd1, 1'b1);
  endtask

  task automatic t_unused_r7();
    for (int c = 4; c <= 6; c++) begin
      code_case("R6", 0, 3'd7, 1'b1);
      code_case("R7", 0, 3'(c), 1'b1);
    end
  endtask

  task automatic t_disabled_r8();
    for (int c = 0; c < 8; c++) begin
      code_case("R6", 1, 3'd7, 1'b1);
      code_case("R8", 1, 3'(c), 1'b0);
    end
  endtask

  task automatic t_hold_r9();
    code_case("R6", 2, 3'd7, 1'b1);
    port_state[2*3 +: 3] = 3'd0; dma_en[2] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", 2, 3'b111);
    port_state[2*3 +: 3] = 3'd1; dma_en[2] = 1'b1;
    @(negedge clk);
    chk("R9", 2, 3'b111);
    pulse(4'b0100, 4'b0100);
    chk("R9", 2, 3'b100);
  endtask

  task automatic t_split_r10();
    code_case("R2", 3, 3'd0, 1'b1);
    port_state[3*3 +: 3] = 3'd7;
    pulse(4'b1000, 4'b0000);
    chk("R10", 3, 3'b110);
    port_state[3*3 +: 3] = 3'd2;
    pulse(4'b0000, 4'b1000);
    chk("R10", 3, 3'b111);
    port_state[3*3 +: 3] = 3'd0;
    pulse(4'b1000, 4'b0000);
    chk("R10", 3, 3'b001);
  endtask

  task automatic t_ports_r11();
    for (int p = 0; p < P; p++) begin
      port_state[p*3 +: 3] = (p % 2 == 0) ? 3'd7 : 3'd3; dma_en[p] = 1'b1;
    end
    pulse('1, '1);
    port_state[0 +: 3] = 3'd0;
    pulse(4'b0001, 4'b0001);
    chk("R11", 0, 3'b000);
    chk("R11", 1, 3'b010);
    chk("R11", 2, 3'b111);
    chk("R11", 3, 3'b010);
  endtask

  initial begin
    rst_n = 1'b0; port_state = '0; dma_en = '0; rx_start = '0; tx_start = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_codes();
    t_unused_r7();
    t_disabled_r8();
    t_hold_r9();
    t_split_r10();
    t_ports_r11();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule